// File: doc/BRIEF.md
# Multi-Channel Timer Output-Compare Unit

This block is a timer peripheral built around a free-running counter with five compare channels. Each channel holds a compare value. On a counting cycle where the counter equals that value, the channel raises its status flag. Four of the channels (the second through the fifth) also drive an output pin. A two-bit action code per pin says what a successful compare does to it: leave it alone, invert it, force it low or force it high. The first channel only raises its flag. Input-capture events come from logic outside the block, already detected, and set their own flags in the same status register.

The fifth compare channel shares its flag and its interrupt enable with the fourth capture source. A mode bit picks which of the two owns that slot. A mask register with the same bit layout as the flag register gates the flags onto one interrupt request line. Software reaches every register through a simple single-cycle write port and a combinational read port.

Top module: `ocu_timer`

## Requirements
- R1: The counter (read at address 0) resets to 0. It increments by one on every clock where `tick_en` is high, holds when `tick_en` is low, and wraps from all ones to 0.
- R2: A compare for channel k (k = 1..5, compare register at address k) succeeds on a clock where `tick_en` is high and the counter equals the compare register. The flag is visible in the next cycle in the flag register (address 8). Flag positions: bit 7 channel 1, bit 6 channel 2, bit 5 channel 3, bit 4 channel 4, bit 3 shared channel-5/capture-4, bit 2 capture 1, bit 1 capture 2, bit 0 capture 3.
- R3: The action register (address 6) holds one two-bit code per pin: bits 7:6 for channel 2 (`oc_pin[0]`), 5:4 for channel 3 (`oc_pin[1]`), 3:2 for channel 4 (`oc_pin[2]`), 1:0 for channel 5 (`oc_pin[3]`). Code 00 leaves the pin at its last value on a successful compare, and a pin never changes on a clock without `tick_en`.
- R4: Code 01 inverts the pin in the cycle after a successful compare.
- R5: Code 10 drives the pin to 0 and code 11 drives it to 1 in the cycle after a successful compare.
- R6: After reset every register reads 0, every pin is 0 and `irq` is 0.
- R7: While the mode bit (address 9, bit 0) is 1, channel 5 produces no flag and no pin change, and `cap_evt[3]` sets flag bit 3 instead. While it is 0, `cap_evt[3]` has no effect.
- R8: Writing the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged. A flag whose set event falls in the same cycle as its clear stays set. Flags change only through set events and such writes.
- R9: `irq` is high exactly when some flag bit and the mask bit in the same position (mask at address 7) are both 1.
- R10: Channel 1 sets flag bit 7 on a successful compare and changes no pin.
- R11: Writes with `wr_en` high load the compare registers (addresses 1 to 5, full width), the action, mask and mode registers. `rdata` shows the register at `addr` in the same cycle, zero-extended. Unused addresses read 0.
- R12: `cap_evt[0]`, `cap_evt[1]` and `cap_evt[2]` set flag bits 2, 1 and 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting enable for this clock |
| cap_evt | input | 4 | Detected capture events, bit i is capture source i+1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Read data for `addr` |
| oc_pin | output | 4 | Compare pins for channels 2 to 5 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear that lands in the very cycle its channel matches. The bench reads the counter through its own reference model and places a compare value a few counts ahead. It then steps until the model counter equals that value and issues the clear write in that cycle. The wrap from all ones to zero needs a full counter period. The bench spends one long run on it, with a compare placed at the top value so that a toggle fires across the wrap.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int unsigned NUM_CMP = 5;
    localparam int unsigned NUM_PIN = 4;
    localparam int unsigned FLAG_W  = 8;

    // register addresses
    localparam int unsigned A_COUNT    = 0;
    localparam int unsigned A_CMP_BASE = 1;
    localparam int unsigned A_ACTION   = 6;
    localparam int unsigned A_MASK     = 7;
    localparam int unsigned A_FLAG     = 8;
    localparam int unsigned A_MODE     = 9;

    // flag / mask bit positions
    localparam int unsigned F_OC1    = 7;
    localparam int unsigned F_OC2    = 6;
    localparam int unsigned F_OC3    = 5;
    localparam int unsigned F_OC4    = 4;
    localparam int unsigned F_SHARED = 3;
    localparam int unsigned F_IC1    = 2;
    localparam int unsigned F_IC2    = 1;
    localparam int unsigned F_IC3    = 0;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic level;
    } pin_state_t;
endpackage

// File: rtl/ocu_counter.sv
module ocu_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.value = st_q.value + 1'b1;   // natural wrap at all ones
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.value;
endmodule

// File: rtl/ocu_pin_chan.sv
module ocu_pin_chan
    import ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] code,
    output logic       pin
);
    pin_state_t st_d, st_q;
    pin_act_e   act;

    assign act = pin_act_e'(code);

    always_comb begin
        st_d = st_q;
        if (hit) begin
            unique case (act)
                ACT_HOLD:   st_d.level = st_q.level;
                ACT_TOGGLE: st_d.level = ~st_q.level;
                ACT_LOW:    st_d.level = 1'b0;
                ACT_HIGH:   st_d.level = 1'b1;
                default:    st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin = st_q.level;
endmodule

// File: rtl/ocu_timer.sv
module ocu_timer
    import ocu_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [3:0]        cap_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_PIN-1:0] oc_pin,
    output logic              irq
);
    localparam int unsigned PAD_W = CNT_W - FLAG_W;

    typedef struct packed {
        logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
        logic [FLAG_W-1:0]             action;
        logic [FLAG_W-1:0]             mask;
        logic [FLAG_W-1:0]             flag;
        logic                          mode;
    } reg_state_t;

    reg_state_t regs_d, regs_q;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_CMP-1:0] hit;
    logic [FLAG_W-1:0]  flag_set;
    logic [FLAG_W-1:0]  flag_clr;
    logic [FLAG_W-1:0]  flag_q;
    logic               mode_q;

    ocu_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (cnt_q)
    );

    // compare match per channel; channel 5 gated by the shared mode bit
    always_comb begin
        for (int k = 0; k < NUM_CMP; k++) begin
            hit[k] = tick_en && (cnt_q == regs_q.cmp[k]);
        end
        hit[NUM_CMP-1] = hit[NUM_CMP-1] && !regs_q.mode;
    end

    always_comb begin
        flag_set           = '0;
        flag_set[F_OC1]    = hit[0];
        flag_set[F_OC2]    = hit[1];
        flag_set[F_OC3]    = hit[2];
        flag_set[F_OC4]    = hit[3];
        flag_set[F_SHARED] = regs_q.mode ? cap_evt[3] : hit[4];
        flag_set[F_IC1]    = cap_evt[0];
        flag_set[F_IC2]    = cap_evt[1];
        flag_set[F_IC3]    = cap_evt[2];
    end

    assign flag_clr = (wr_en && addr == ADDR_W'(A_FLAG)) ? wdata[FLAG_W-1:0] : '0;

    always_comb begin
        regs_d      = regs_q;
        regs_d.flag = (regs_q.flag & ~flag_clr) | flag_set;
        if (wr_en) begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (addr == ADDR_W'(A_CMP_BASE + k)) begin
                    regs_d.cmp[k] = wdata;
                end
            end
            if (addr == ADDR_W'(A_ACTION)) regs_d.action = wdata[FLAG_W-1:0];
            if (addr == ADDR_W'(A_MASK))   regs_d.mask   = wdata[FLAG_W-1:0];
            if (addr == ADDR_W'(A_MODE))   regs_d.mode   = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // pins for channels 2..5; pin g uses code pair at bits (7-2g):(6-2g)
    for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
        ocu_pin_chan u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[g+1]),
            .code  (regs_q.action[FLAG_W-1-2*g -: 2]),
            .pin   (oc_pin[g])
        );
    end

    // read port
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_COUNT)) rdata = cnt_q;
        for (int k = 0; k < NUM_CMP; k++) begin
            if (addr == ADDR_W'(A_CMP_BASE + k)) rdata = regs_q.cmp[k];
        end
        if (addr == ADDR_W'(A_ACTION)) rdata = {{PAD_W{1'b0}}, regs_q.action};
        if (addr == ADDR_W'(A_MASK))   rdata = {{PAD_W{1'b0}}, regs_q.mask};
        if (addr == ADDR_W'(A_FLAG))   rdata = {{PAD_W{1'b0}}, regs_q.flag};
        if (addr == ADDR_W'(A_MODE))   rdata = {{(CNT_W-1){1'b0}}, regs_q.mode};
    end

    assign irq    = |(regs_q.flag & regs_q.mask);
    assign flag_q = regs_q.flag;
    assign mode_q = regs_q.mode;
endmodule

// File: rtl/ocu_timer_chk.sv
module ocu_timer_chk
    import ocu_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  count,
    input logic [FLAG_W-1:0] flags,
    input logic              mode,
    input logic [NUM_PIN-1:0] oc_pin,
    input logic              irq
);
    // R1: counting step
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == CNT_W'($past(count) + 1'b1));

    // R1: counter holds without a tick
    p_cnt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    // R3: pins move only on counting cycles
    p_pin_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(oc_pin));

    // R7: shared channel in capture mode leaves its pin alone
    p_shared_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> $stable(oc_pin[NUM_PIN-1]));

    // R8: flags never drop without a flag-register write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(A_FLAG)) |=> ((flags & $past(flags)) == $past(flags)));

    // R9: a request needs a pending flag
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

bind ocu_timer ocu_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .count   (cnt_q),
    .flags   (flag_q),
    .mode    (mode_q),
    .oc_pin  (oc_pin),
    .irq     (irq)
);

// File: tb/tb_ocu_timer.sv
`timescale 1ns/1ps
module tb_ocu_timer;
    localparam int CLK_NS = 8;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_tick = 1'b0;
    logic [3:0]  d_cap = '0;
    logic        d_wr = 1'b0;
    logic [3:0]  d_addr = '0;
    logic [15:0] d_wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  oc_pin;
    logic        irq;

    int checks = 0;
    int errors = 0;
    string phase = "R6";

    // reference model state
    int   m_cnt;
    int   m_cmp [5];
    int   m_act, m_mask, m_flag, m_mode;
    bit [3:0] m_pin;

    always #(CLK_NS/2) clk = ~clk;

    ocu_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(d_tick), .cap_evt(d_cap),
        .wr_en(d_wr), .addr(d_addr), .wdata(d_wdata),
        .rdata(rdata), .oc_pin(oc_pin), .irq(irq)
    );

    function automatic void model_reset();
        m_cnt = 0; m_act = 0; m_mask = 0; m_flag = 0; m_mode = 0; m_pin = '0;
        for (int k = 0; k < 5; k++) m_cmp[k] = 0;
    endfunction

    function automatic int model_read(int a);
        if (a == 0) return m_cnt;
        if (a >= 1 && a <= 5) return m_cmp[a-1];
        if (a == 6) return m_act;
        if (a == 7) return m_mask;
        if (a == 8) return m_flag;
        if (a == 9) return m_mode;
        return 0;
    endfunction

    function automatic void model_step();
        bit hits [5];
        int setv, clrv, code;
        for (int k = 0; k < 5; k++) hits[k] = d_tick && (m_cnt == m_cmp[k]);
        if (m_mode != 0) hits[4] = 0;
        setv = 0;
        if (hits[0]) setv |= 8'h80;
        if (hits[1]) setv |= 8'h40;
        if (hits[2]) setv |= 8'h20;
        if (hits[3]) setv |= 8'h10;
        if ((m_mode != 0) ? d_cap[3] : hits[4]) setv |= 8'h08;
        if (d_cap[0]) setv |= 8'h04;
        if (d_cap[1]) setv |= 8'h02;
        if (d_cap[2]) setv |= 8'h01;
        clrv = (d_wr && d_addr == 8) ? int'(d_wdata[7:0]) : 0;
        for (int p = 0; p < 4; p++) begin
            if (hits[p+1]) begin
                code = (m_act >> (6 - 2*p)) & 3;
                if (code == 1) m_pin[p] = ~m_pin[p];
                else if (code == 2) m_pin[p] = 1'b0;
                else if (code == 3) m_pin[p] = 1'b1;
            end
        end
        m_flag = (m_flag & ~clrv & 8'hFF) | setv;
        if (d_tick) m_cnt = (m_cnt + 1) & 16'hFFFF;
        if (d_wr) begin
            if (d_addr >= 1 && d_addr <= 5) m_cmp[d_addr-1] = int'(d_wdata);
            if (d_addr == 6) m_act  = int'(d_wdata[7:0]);
            if (d_addr == 7) m_mask = int'(d_wdata[7:0]);
            if (d_addr == 9) m_mode = int'(d_wdata[0]);
        end
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        string rtag;
        int code;
        if (d_addr == 0) rtag = "R1 counter";
        else if (d_addr == 8) rtag = "R2 flags";
        else if (d_addr == 9) rtag = "R7 mode";
        else rtag = "R11 read";
        check_val(rtag, int'(rdata), model_read(int'(d_addr)));
        for (int p = 0; p < 4; p++) begin
            code = (m_act >> (6 - 2*p)) & 3;
            if (p == 3 && m_mode != 0) check_val("R7 pin", int'(oc_pin[p]), int'(m_pin[p]));
            else if (code == 0) check_val("R3 pin", int'(oc_pin[p]), int'(m_pin[p]));
            else if (code == 1) check_val("R4 pin", int'(oc_pin[p]), int'(m_pin[p]));
            else check_val("R5 pin", int'(oc_pin[p]), int'(m_pin[p]));
        end
        check_val("R9 irq", int'(irq), ((m_flag & m_mask) != 0) ? 1 : 0);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(int a, int v);
        d_wr = 1'b1; d_addr = 4'(a); d_wdata = 16'(v);
        cycle();
        d_wr = 1'b0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog [%s] actual=running expected=done", phase);
        finish_sim();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset values on every address
        phase = "R6";
        for (int a = 0; a < 12; a++) begin
            d_addr = 4'(a);
            #1;
            check_val("R6 reset read", int'(rdata), 0);
            check_outputs();
        end
        check_val("R6 pins", int'(oc_pin), 0);
        check_val("R6 irq", int'(irq), 0);

        // R11 register loads; R4/R5 pin actions; R10 channel 1 has no pin
        phase = "R11";
        wr(1, 20); wr(2, 25); wr(3, 30); wr(4, 35); wr(5, 40);
        wr(6, 8'b01_11_10_01);          // OC2 toggle, OC3 high, OC4 low, OC5 toggle
        d_addr = 8; d_tick = 1'b1;
        phase = "R4 R5 R10";
        run(60);
        check_val("R2 flags after sweep", int'(rdata[7:0]), 8'hF8);
        check_val("R10 pins after sweep", int'(oc_pin), 4'b1011);

        // R8 writing zeros keeps flags, writing ones clears them
        phase = "R8";
        wr(8, 0);
        d_addr = 8; #1;
        check_val("R8 zero write", int'(rdata[7:0]), 8'hF8);
        wr(8, 8'h30);
        d_addr = 8; #1;
        check_val("R8 partial clear", int'(rdata[7:0]), 8'hC8);
        wr(8, 8'hFF);

        // R8 set wins over clear in the same cycle
        begin
            int tgt;
            tgt = (m_cnt + 6) & 16'hFFFF;
            wr(1, tgt);
            d_addr = 0;
            while (m_cnt != tgt) cycle();
            wr(8, 8'h80);
            d_addr = 8; #1;
            check_val("R8 set beats clear", int'(rdata[7]), 1);
        end

        // R3 hold code and tick gaps; R9 masking
        phase = "R3 R9";
        wr(8, 8'hFF);
        wr(7, 8'h40);
        wr(6, 8'b00_00_01_11);
        for (int k = 0; k < 4; k++) wr(2 + k, (m_cnt + 4 + 3*k) & 16'hFFFF);
        d_addr = 8;
        for (int i = 0; i < 60; i++) begin
            d_tick = (i % 3) != 1;
            cycle();
        end
        d_tick = 1'b1;
        check_val("R9 irq from OC2", int'(irq), 1);
        wr(7, 8'h00);
        d_addr = 7; #1;
        check_val("R9 masked", int'(irq), 0);

        // R7 shared slot in capture mode; R12 capture flags
        phase = "R7 R12";
        wr(8, 8'hFF);
        wr(6, 8'b00_00_00_01);
        wr(9, 1);
        wr(5, (m_cnt + 3) & 16'hFFFF);
        d_addr = 8;
        run(10);
        check_val("R7 no compare flag", int'(rdata[3]), 0);
        d_cap = 4'b1000; cycle(); d_cap = 4'b0000; cycle();
        check_val("R7 capture flag", int'(rdata[3]), 1);
        d_cap = 4'b0111; cycle(); d_cap = 4'b0000; cycle();
        check_val("R12 capture flags", int'(rdata[2:0]), 7);
        wr(9, 0);
        wr(8, 8'hFF);
        d_addr = 8;
        d_cap = 4'b1000; cycle(); d_cap = 4'b0000; cycle();
        check_val("R7 capture ignored", int'(rdata[3]), 0);
        wr(7, 8'h08);
        wr(5, (m_cnt + 3) & 16'hFFFF);
        d_addr = 8;
        run(8);
        check_val("R7 compare flag back", int'(rdata[3]), 1);

        // R1 wrap with a toggle at the top value
        phase = "R1";
        wr(8, 8'hFF);
        wr(6, 8'b01_00_00_00);
        wr(2, 16'hFFFF);
        wr(3, 0);
        d_addr = 0;
        run(65600);
        check_val("R1 counter moving", int'(rdata != 0), 1);

        finish_sim();
    end
endmodule